// File: doc/BRIEF.md
# Partial Word Store Byte-Lane Unit

This unit converts a single store-bytes request into one aligned 32-bit write to a big-endian memory. A request carries a byte address, a register value and a mode. In begin mode the low-order bytes of the register are written from the addressed byte up to the last byte of its word. In end mode the high-order bytes of the register fill the part of the word that lies below the addressed byte. The three-byte cases come out as one write with three byte enables, not as a split pair. When end mode addresses offset 0, no bytes are due, and the unit raises a probe-only indication instead of a write. This lets a downstream stage still check write permission for that address.

The register value keeps its lane position in every case. Each register byte already sits in the lane it is written to, so the unit only picks the enables and clears the unused lanes. The result appears one clock after the request. A small state machine holds the kind of result issued in the current cycle. Its states are ST_IDLE (nothing issued), ST_WRITE (a write with at least one enable) and ST_PROBE (a probe-only result with no enables). Each cycle it takes one of three transitions. Any state goes to ST_WRITE on a request that enables some lane, to ST_PROBE on a request that enables none, and to ST_IDLE when no request is present.

Top module: `pws_store_unit`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released with no request, wr_valid and probe_only are 0 and wr_be is 0000.
- R2: wr_addr equals the request address with its two low bits cleared.
- R3: With req_mode = 0 (begin), byte offset 0/1/2/3 yields wr_be = 1111/0111/0011/0001, where wr_be bit 3 is byte offset 0 and data bits 31:24, down to bit 0 for offset 3 and bits 7:0.
- R4: With req_mode = 1 (end), byte offset 3/2/1 yields wr_be = 1110/1100/1000.
- R5: With req_mode = 1 and byte offset 0, wr_valid is 0, probe_only is 1 and wr_be is 0000; a write result has wr_valid 1 and probe_only 0.
- R6: Each enabled lane of wr_data carries the request data byte of the same lane, and each disabled lane is 0.
- R7: Results appear on the clock edge after the request. A cycle with req_valid low yields wr_valid and probe_only low on the next edge.
- R8: Back-to-back requests in consecutive cycles each produce their own result in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store-bytes request present |
| req_mode | input | 1 | 0 = begin mode, 1 = end mode |
| req_addr | input | 32 | Byte address of the request |
| req_data | input | 32 | Register value to store |
| wr_addr | output | 32 | Word-aligned write address |
| wr_be | output | 4 | Byte enables, bit 3 = byte offset 0 |
| wr_data | output | 32 | Lane-aligned write data, disabled lanes zero |
| wr_valid | output | 1 | Write issued this cycle |
| probe_only | output | 1 | Zero-byte probe issued this cycle |

## Verification
The table covers all four offsets in both modes, and each offset uses distinct byte values so that a lane swap or a shifted enable shows up. Repeating a three-byte case with all-ones data at the top of the address space shows whether lane clearing and address alignment are correct, apart from the data pattern. The end-mode offset-0 entry is the only one that must give a probe and no write, so it separates the probe path from the write path. Directed runs then check the idle gap after a request, a pair of back-to-back requests in different modes, and a reset applied while a result is pending.

// File: rtl/pws_pkg.sv
package pws_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_PROBE = 2'd2
    } issue_state_t;

    typedef enum logic {
        MODE_BEGIN = 1'b0,
        MODE_END   = 1'b1
    } store_mode_t;
endpackage

// File: rtl/pws_lane_decode.sv
module pws_lane_decode #(
    parameter int BYTES = 4,
    localparam int OFF_W = $clog2(BYTES)
) (
    input  logic             mode,
    input  logic [OFF_W-1:0] offset,
    output logic [BYTES-1:0] lane_en
);
    import pws_pkg::*;

    // byte offset i lives in enable bit BYTES-1-i (big-endian lanes)
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        localparam logic [OFF_W-1:0] POS = OFF_W'(i);
        always_comb begin
            if (store_mode_t'(mode) == MODE_END)
                lane_en[BYTES-1-i] = (POS < offset);
            else
                lane_en[BYTES-1-i] = (POS >= offset);
        end
    end
endmodule

// File: rtl/pws_lane_pack.sv
module pws_lane_pack #(
    parameter int BYTES = 4,
    localparam int DATA_W = 8 * BYTES
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic [BYTES-1:0]  lane_en,
    output logic [DATA_W-1:0] data_out
);
    for (genvar j = 0; j < BYTES; j++) begin : g_byte
        assign data_out[8*j +: 8] = lane_en[j] ? data_in[8*j +: 8] : 8'h00;
    end
endmodule

// File: rtl/pws_issue_fsm.sv
module pws_issue_fsm #(
    parameter int BYTES  = 4,
    parameter int ADDR_W = 32,
    localparam int DATA_W = 8 * BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BYTES-1:0]  be_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [BYTES-1:0]  be_q,
    output logic [DATA_W-1:0] data_q,
    output logic              write_o,
    output logic              probe_o
);
    import pws_pkg::*;

    issue_state_t state, state_n;

    always_comb begin
        if (!req_valid)
            state_n = ST_IDLE;
        else if (|be_in)
            state_n = ST_WRITE;
        else
            state_n = ST_PROBE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            be_q   <= '0;
            data_q <= '0;
        end else begin
            state <= state_n;
            if (req_valid) begin
                addr_q <= addr_in;
                be_q   <= be_in;
                data_q <= data_in;
            end else begin
                be_q   <= '0;
            end
        end
    end

    always_comb begin
        write_o = 1'b0;
        probe_o = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_WRITE: write_o = 1'b1;
            ST_PROBE: probe_o = 1'b1;
            default:  ;
        endcase
    end

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state inside {ST_IDLE, ST_WRITE, ST_PROBE}); // R7
    AST_IDLE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (state == ST_IDLE)); // R7
    AST_NEXT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (state != ST_IDLE)); // R8
endmodule

// File: rtl/pws_store_unit.sv
module pws_store_unit #(
    parameter int BYTES  = 4,
    parameter int ADDR_W = 32,
    localparam int DATA_W = 8 * BYTES,
    localparam int OFF_W  = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_mode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTES-1:0]  wr_be,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_valid,
    output logic              probe_only
);
    logic [BYTES-1:0]  lane_en;
    logic [DATA_W-1:0] packed_data;
    logic [ADDR_W-1:0] aligned_addr;

    assign aligned_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    pws_lane_decode #(.BYTES(BYTES)) u_decode (
        .mode    (req_mode),
        .offset  (req_addr[OFF_W-1:0]),
        .lane_en (lane_en)
    );

    pws_lane_pack #(.BYTES(BYTES)) u_pack (
        .data_in  (req_data),
        .lane_en  (lane_en),
        .data_out (packed_data)
    );

    pws_issue_fsm #(.BYTES(BYTES), .ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .addr_in   (aligned_addr),
        .be_in     (lane_en),
        .data_in   (packed_data),
        .addr_q    (wr_addr),
        .be_q      (wr_be),
        .data_q    (wr_data),
        .write_o   (wr_valid),
        .probe_o   (probe_only)
    );

    AST_WRITE_OR_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && probe_only)); // R5
    AST_PROBE_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        probe_only |-> (wr_be == '0)); // R5
    AST_WRITE_HAS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_be != '0)); // R3
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid || probe_only) |-> (wr_addr[OFF_W-1:0] == '0)); // R2
    AST_END_ZERO_PROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode && req_addr[OFF_W-1:0] == '0) |=> probe_only); // R5

    for (genvar k = 0; k < BYTES; k++) begin : g_chk
        AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_valid && !wr_be[k]) |-> (wr_data[8*k +: 8] == 8'h00)); // R6
    end
endmodule

// File: tb/sim_pws_store_unit.sv
module sim_pws_store_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_mode = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic [31:0] wr_addr;
    logic [3:0]  wr_be;
    logic [31:0] wr_data;
    logic        wr_valid;
    logic        probe_only;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pws_store_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_addr(req_addr), .req_data(req_data), .wr_addr(wr_addr),
        .wr_be(wr_be), .wr_data(wr_data), .wr_valid(wr_valid),
        .probe_only(probe_only)
    );

    // {mode, addr, data, expected enables}
    localparam logic [68:0] VEC [0:NV-1] = '{
        {1'b0, 32'h0000_1000, 32'hA1B2_C3D4, 4'b1111},
        {1'b0, 32'h0000_2001, 32'h1122_3344, 4'b0111},
        {1'b0, 32'h0000_3002, 32'h5566_7788, 4'b0011},
        {1'b0, 32'h0000_4003, 32'h99AA_BBCC, 4'b0001},
        {1'b1, 32'h0000_5007, 32'hDEAD_BEEF, 4'b1110},
        {1'b1, 32'h0000_6006, 32'hCAFE_F00D, 4'b1100},
        {1'b1, 32'h0000_7005, 32'h0123_4567, 4'b1000},
        {1'b1, 32'h0000_8004, 32'h89AB_CDEF, 4'b0000},
        {1'b0, 32'hFFFF_FFFD, 32'hFFFF_FFFF, 4'b0111},
        {1'b1, 32'h0000_000B, 32'h1234_5678, 4'b1110}
    };

    function automatic logic [31:0] lanes(input logic [31:0] d, input logic [3:0] be);
        logic [31:0] r = '0;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_result(input logic [68:0] v);
        logic [3:0] be = v[3:0];
        chk("R2 addr", wr_addr, {v[67:36] >> 2, 2'b00});
        chk(v[68] ? "R4 be" : "R3 be", {28'h0, wr_be}, {28'h0, be});
        chk("R6 data", wr_data, lanes(v[35:4], be));
        chk("R5 valid", {31'h0, wr_valid}, {31'h0, be != 4'b0000});
        chk("R5 probe", {31'h0, probe_only}, {31'h0, be == 4'b0000});
    endtask

    task automatic drive(input logic [68:0] v);
        req_valid = 1'b1;
        req_mode  = v[68];
        req_addr  = v[67:36];
        req_data  = v[35:4];
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {31'h0, wr_valid}, 32'h0);
        chk("R1 probe in reset", {31'h0, probe_only}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 be after reset", {28'h0, wr_be}, 32'h0);
        chk("R1 valid after reset", {31'h0, wr_valid}, 32'h0);

        // table walk, one request then one idle cycle
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            req_valid = 1'b0;
            expect_result(VEC[i]);
            @(negedge clk);
            chk("R7 valid idle", {31'h0, wr_valid}, 32'h0);
            chk("R7 probe idle", {31'h0, probe_only}, 32'h0);
        end

        // R8: back-to-back, write then probe then write
        drive(VEC[2]);
        @(negedge clk);
        drive(VEC[7]);
        expect_result(VEC[2]);
        @(negedge clk);
        drive(VEC[4]);
        expect_result(VEC[7]);
        @(negedge clk);
        req_valid = 1'b0;
        expect_result(VEC[4]);

        // R1: reset while a result is pending
        @(negedge clk);
        drive(VEC[0]);
        rst_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 valid reset over request", {31'h0, wr_valid}, 32'h0);
        chk("R1 be reset over request", {28'h0, wr_be}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 quiet after reset", {31'h0, wr_valid | probe_only}, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule